// File: doc/BRIEF.md
# Bidirectional Byte Mailbox Bank

This block passes short messages and semaphores between a host on a system bus and the back-end logic that sits behind it. It holds two 64-bit mailbox words. The inbound word carries eight one-byte mailboxes from the host to the back-end. The outbound word carries eight one-byte mailboxes from the back-end to the host. Each of the two sides has its own register port with write and read strobes, a 2-bit word index and 8 byte enables. Both ports sample on a single shared clock.

Every mailbox byte has a full flag. A byte-enabled write by the sender fills a byte, and a byte-enabled read by the receiver drains it. Each side keeps a sticky event register and a mask register of its own. The event register records when its incoming mail arrives and when its outgoing mail has been taken. The mask register selects which of those events drive the side's interrupt line. The address decode that places the bank in the control space is done outside this block.

Word index map for both ports: 0 = inbound mailbox word, 1 = outbound mailbox word, 2 = event/status word, 3 = mask word.

Top module: `mbox_bank`

## Requirements
- R1: After reset every full flag, every event bit and every mask bit is 0, both interrupt lines are low, and the mailbox words read as zero.
- R2: A host write to word 0 stores each enabled byte i (bits 8i+7..8i) and sets that byte's inbound full flag from the next cycle on. The back-end status word shows the inbound full flags in bits 23:16, and the host status word shows them in bits 31:24.
- R3: A back-end read of word 0 returns all 64 inbound bits in the same cycle. From the next cycle it clears the full flag of each enabled byte.
- R4: The outbound direction behaves as R2 and R3 with the roles swapped: the back-end writes word 1 and the host reads it. The host status word shows the outbound full flags in bits 23:16, and the back-end status word shows them in bits 31:24.
- R5: Each byte i that a sender writes sets event bit i in the receiver's status word. Each full byte i that a receiver drains sets event bit 8+i in the sender's status word. Event bits stay set until they are cleared.
- R6: Writing word 2 clears each event bit that is written as 1 inside an enabled byte: byte enable 0 covers bits 7:0 and byte enable 1 covers bits 15:8. Zeros and disabled bytes leave bits unchanged. An event that arrives in the same cycle as its clear keeps the bit set.
- R7: Word 3 holds a 16-bit mask per side, written per enabled byte and read back in bits 15:0. A side's interrupt is high exactly while an event bit of that side is set together with its mask bit. The interrupt follows the register state with no added delay.
- R8: A side's write to the mailbox word it receives has no effect. Writes to status bits 31:16 also have no effect.
- R9: When a byte is written and drained in the same cycle, the read returns the old value, the new value is stored, and the full flag stays set.
- R10: A read leaves the full flag of each disabled byte unchanged. Draining a byte that is already empty sets no event bit.
- R11: Writing a byte that is already full replaces its data, keeps the flag set and raises its arrival event again.
- R12: Read data is zero in any cycle where that side's read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host write strobe |
| h_re | input | 1 | Host read strobe |
| h_addr | input | 2 | Host word index |
| h_be | input | 8 | Host byte enables |
| h_wdata | input | 64 | Host write data |
| h_rdata | output | 64 | Host read data (combinational) |
| h_irq | output | 1 | Host interrupt |
| b_we | input | 1 | Back-end write strobe |
| b_re | input | 1 | Back-end read strobe |
| b_addr | input | 2 | Back-end word index |
| b_be | input | 8 | Back-end byte enables |
| b_wdata | input | 64 | Back-end write data |
| b_rdata | output | 64 | Back-end read data (combinational) |
| b_irq | output | 1 | Back-end interrupt |

## Verification
Read data is due in the same cycle as the read strobe. Full flags, event bits, masks and stored bytes change at the edge that samples a write or read, so they can be seen from the next cycle on. The interrupt lines are decoded from those registers, so they follow the same one-edge rule. The bench drives each cycle's inputs just after the falling edge and compares both read buses and both interrupt lines with its model 2 ns before the rising edge. It then applies that cycle's effects to the model at the rising edge, so every expected value already includes all edges up to that point.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    MB_IN   = 2'd0,
    MB_OUT  = 2'd1,
    MB_STAT = 2'd2,
    MB_MASK = 2'd3
  } mb_reg_e;
endpackage

// File: rtl/mbox_dir.sv
module mbox_dir #(
  parameter int LANES = 8,
  parameter int LW    = 8,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_be,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [LANES-1:0] rd_be,
  output logic [DW-1:0]    box_q,
  output logic [LANES-1:0] full_q,
  output logic [LANES-1:0] fill_ev,
  output logic [LANES-1:0] drain_ev
);
  logic [LW-1:0] lane_q [LANES];

  function automatic logic [LANES-1:0] full_next(input logic [LANES-1:0] cur,
                                                 input logic [LANES-1:0] fill,
                                                 input logic [LANES-1:0] drain);
    return (cur & ~drain) | fill;
  endfunction

  assign fill_ev  = wr_en ? wr_be : '0;
  assign drain_ev = rd_en ? (rd_be & full_q) : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)          lane_q[i] <= '0;
      else if (fill_ev[i]) lane_q[i] <= wr_data[i*LW +: LW];
    end
    assign box_q[i*LW +: LW] = lane_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) full_q <= '0;
    else        full_q <= full_next(full_q, fill_ev, drain_ev);
  end

  // R2, R11: a filled lane reads full on the next cycle
  a_r2_fill_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    (|fill_ev) |=> ((full_q & $past(fill_ev)) == $past(fill_ev)));
  // R3, R9: a drained lane is empty next cycle unless refilled
  a_r3_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|drain_ev) |=> ((full_q & $past(drain_ev & ~fill_ev)) == '0));
  // R10: no lane becomes full without a write
  a_r10_no_stray_full: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((full_q & ~$past(full_q) & ~$past(fill_ev)) == '0));
  // R8: stored bytes hold when nothing is written
  a_r8_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ev == '0) |=> $stable(box_q));
endmodule

// File: rtl/mbox_side.sv
module mbox_side #(
  parameter int LANES = 8,
  localparam int SW   = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] arrive_ev,
  input  logic [LANES-1:0] taken_ev,
  input  logic             stat_we,
  input  logic             mask_we,
  input  logic [SW-1:0]    wdata,
  input  logic [1:0]       wbe,
  output logic [SW-1:0]    stat_q,
  output logic [SW-1:0]    mask_q,
  output logic             irq
);
  logic [SW-1:0] be_bits;
  logic [SW-1:0] set_bits;
  logic [SW-1:0] clr_bits;

  function automatic logic [SW-1:0] sticky_next(input logic [SW-1:0] cur,
                                                input logic [SW-1:0] set,
                                                input logic [SW-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [SW-1:0] merge(input logic [SW-1:0] cur,
                                          input logic [SW-1:0] wd,
                                          input logic [SW-1:0] en);
    return (cur & ~en) | (wd & en);
  endfunction

  assign be_bits  = {{LANES{wbe[1]}}, {LANES{wbe[0]}}};
  assign set_bits = {taken_ev, arrive_ev};
  assign clr_bits = stat_we ? (wdata & be_bits) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= sticky_next(stat_q, set_bits, clr_bits);
      if (mask_we) mask_q <= merge(mask_q, wdata, be_bits);
    end
  end

  assign irq = |(stat_q & mask_q);

  // R7: an unmasked event raises the interrupt on the next cycle
  a_r7_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(set_bits & mask_q)) && !mask_we) |=> irq);
  // R1, R7: no mask, no interrupt
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  // R5: status bits only appear from events
  a_r5_no_stray_status: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(set_bits)) == '0));
  // R6: an arriving event survives a same-cycle clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_bits) |=> ((stat_q & $past(set_bits)) == $past(set_bits)));
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int LANES = 8,
  parameter int LW    = 8,
  localparam int DW   = LANES * LW,
  localparam int SW   = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_we,
  input  logic             h_re,
  input  logic [1:0]       h_addr,
  input  logic [LANES-1:0] h_be,
  input  logic [DW-1:0]    h_wdata,
  output logic [DW-1:0]    h_rdata,
  output logic             h_irq,
  input  logic             b_we,
  input  logic             b_re,
  input  logic [1:0]       b_addr,
  input  logic [LANES-1:0] b_be,
  input  logic [DW-1:0]    b_wdata,
  output logic [DW-1:0]    b_rdata,
  output logic             b_irq
);
  import mbox_pkg::*;

  mb_reg_e ha, ba;
  logic [DW-1:0]    in_box, out_box;
  logic [LANES-1:0] in_full, out_full;
  logic [LANES-1:0] in_fill, in_drain, out_fill, out_drain;
  logic [SW-1:0]    h_stat, h_mask, b_stat, b_mask;
  logic             h_in_wr, b_out_wr, h_out_rd, b_in_rd;

  assign ha = mb_reg_e'(h_addr);
  assign ba = mb_reg_e'(b_addr);

  assign h_in_wr  = h_we && (ha == MB_IN);
  assign b_out_wr = b_we && (ba == MB_OUT);
  assign h_out_rd = h_re && (ha == MB_OUT);
  assign b_in_rd  = b_re && (ba == MB_IN);

  function automatic logic [DW-1:0] read_mux(input logic re, input mb_reg_e a,
                                             input logic [DW-1:0] inb,
                                             input logic [DW-1:0] outb,
                                             input logic [SW-1:0] st,
                                             input logic [SW-1:0] mk,
                                             input logic [LANES-1:0] rcv_full,
                                             input logic [LANES-1:0] snd_full);
    logic [DW-1:0] r;
    r = '0;
    if (re) begin
      case (a)
        MB_IN:   r = inb;
        MB_OUT:  r = outb;
        MB_STAT: r[4*LANES-1:0] = {snd_full, rcv_full, st};
        default: r[SW-1:0] = mk;
      endcase
    end
    return r;
  endfunction

  mbox_dir #(.LANES(LANES), .LW(LW)) u_inbound (
    .clk(clk), .rst_n(rst_n),
    .wr_en(h_in_wr), .wr_be(h_be), .wr_data(h_wdata),
    .rd_en(b_in_rd), .rd_be(b_be),
    .box_q(in_box), .full_q(in_full), .fill_ev(in_fill), .drain_ev(in_drain)
  );

  mbox_dir #(.LANES(LANES), .LW(LW)) u_outbound (
    .clk(clk), .rst_n(rst_n),
    .wr_en(b_out_wr), .wr_be(b_be), .wr_data(b_wdata),
    .rd_en(h_out_rd), .rd_be(h_be),
    .box_q(out_box), .full_q(out_full), .fill_ev(out_fill), .drain_ev(out_drain)
  );

  mbox_side #(.LANES(LANES)) u_host_side (
    .clk(clk), .rst_n(rst_n),
    .arrive_ev(out_fill), .taken_ev(in_drain),
    .stat_we(h_we && (ha == MB_STAT)), .mask_we(h_we && (ha == MB_MASK)),
    .wdata(h_wdata[SW-1:0]), .wbe(h_be[1:0]),
    .stat_q(h_stat), .mask_q(h_mask), .irq(h_irq)
  );

  mbox_side #(.LANES(LANES)) u_back_side (
    .clk(clk), .rst_n(rst_n),
    .arrive_ev(in_fill), .taken_ev(out_drain),
    .stat_we(b_we && (ba == MB_STAT)), .mask_we(b_we && (ba == MB_MASK)),
    .wdata(b_wdata[SW-1:0]), .wbe(b_be[1:0]),
    .stat_q(b_stat), .mask_q(b_mask), .irq(b_irq)
  );

  assign h_rdata = read_mux(h_re, ha, in_box, out_box, h_stat, h_mask, out_full, in_full);
  assign b_rdata = read_mux(b_re, ba, in_box, out_box, b_stat, b_mask, in_full, out_full);

  // R8: a host write aimed at the outbound word leaves it untouched
  a_r8_host_no_outbound_write: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && (ha == MB_OUT) && !b_out_wr) |=> $stable(out_box));
  // R8: a back-end write aimed at the inbound word leaves it untouched
  a_r8_back_no_inbound_write: assert property (@(posedge clk) disable iff (!rst_n)
    (b_we && (ba == MB_IN) && !h_in_wr) |=> $stable(in_box));
  // R12: no read strobe, no read data
  a_r12_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_re |-> (h_rdata == '0)) and (!b_re |-> (b_rdata == '0)));
endmodule

// File: tb/mbox_bank_tb.sv
module mbox_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_we = 0, h_re = 0, b_we = 0, b_re = 0;
  logic [1:0]  h_addr = 0, b_addr = 0;
  logic [7:0]  h_be = 0, b_be = 0;
  logic [63:0] h_wdata = 0, b_wdata = 0;
  logic [63:0] h_rdata, b_rdata;
  logic        h_irq, b_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  logic [63:0] m_in = 0, m_out = 0;
  logic [7:0]  m_inf = 0, m_outf = 0;
  logic [15:0] m_hs = 0, m_bs = 0, m_hm = 0, m_bm = 0;

  always #10 clk = ~clk;

  mbox_bank dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_we(h_we), .h_re(h_re), .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq(h_irq),
    .b_we(b_we), .b_re(b_re), .b_addr(b_addr), .b_be(b_be), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  function automatic logic [63:0] exp_read(input bit host, input logic re, input logic [1:0] a);
    logic [63:0] r = 64'h0;
    if (!re) return r;
    if (a == 2'd0) r = m_in;
    else if (a == 2'd1) r = m_out;
    else if (a == 2'd2) r = host ? {32'h0, m_inf, m_outf, m_hs} : {32'h0, m_outf, m_inf, m_bs};
    else r = host ? {48'h0, m_hm} : {48'h0, m_bm};
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [15:0] hclr = 0, bclr = 0;
    logic [7:0]  inf_n = m_inf, outf_n = m_outf;
    logic [15:0] hs_set = 0, bs_set = 0;
    for (int i = 0; i < 8; i++) begin
      bit inw  = h_we && h_addr == 2'd0 && h_be[i];
      bit outw = b_we && b_addr == 2'd1 && b_be[i];
      bit ind  = b_re && b_addr == 2'd0 && b_be[i] && m_inf[i];
      bit outd = h_re && h_addr == 2'd1 && h_be[i] && m_outf[i];
      if (ind)  inf_n[i] = 0;
      if (outd) outf_n[i] = 0;
      if (inw)  begin inf_n[i] = 1;  m_in[i*8 +: 8]  = h_wdata[i*8 +: 8]; end
      if (outw) begin outf_n[i] = 1; m_out[i*8 +: 8] = b_wdata[i*8 +: 8]; end
      if (outw) hs_set[i] = 1;
      if (ind)  hs_set[8+i] = 1;
      if (inw)  bs_set[i] = 1;
      if (outd) bs_set[8+i] = 1;
    end
    for (int j = 0; j < 16; j++) begin
      if (h_we && h_addr == 2'd2 && h_be[j/8] && h_wdata[j]) hclr[j] = 1;
      if (b_we && b_addr == 2'd2 && b_be[j/8] && b_wdata[j]) bclr[j] = 1;
      if (h_we && h_addr == 2'd3 && h_be[j/8]) m_hm[j] = h_wdata[j];
      if (b_we && b_addr == 2'd3 && b_be[j/8]) m_bm[j] = b_wdata[j];
    end
    m_hs = (m_hs & ~hclr) | hs_set;
    m_bs = (m_bs & ~bclr) | bs_set;
    m_inf = inf_n;
    m_outf = outf_n;
  endtask

  task automatic cyc(input string tag,
                     input logic hwe, input logic hre, input logic [1:0] ha, input logic [7:0] hbe, input logic [63:0] hwd,
                     input logic bwe, input logic bre, input logic [1:0] ba, input logic [7:0] bbe, input logic [63:0] bwd);
    @(negedge clk);
    h_we = hwe; h_re = hre; h_addr = ha; h_be = hbe; h_wdata = hwd;
    b_we = bwe; b_re = bre; b_addr = ba; b_be = bbe; b_wdata = bwd;
    #8;
    check(tag, "h_rdata", h_rdata, exp_read(1, hre, ha));
    check(tag, "b_rdata", b_rdata, exp_read(0, bre, ba));
    check(tag, "h_irq", {63'h0, h_irq}, {63'h0, |(m_hs & m_hm)});
    check(tag, "b_irq", {63'h0, b_irq}, {63'h0, |(m_bs & m_bm)});
    @(posedge clk);
    model_step();
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every readable word
    cyc("R1", 0, 1, 2'd2, 8'hFF, 0, 0, 1, 2'd2, 8'hFF, 0);
    cyc("R1", 0, 1, 2'd3, 8'hFF, 0, 0, 1, 2'd3, 8'hFF, 0);
    cyc("R1", 0, 1, 2'd0, 8'h00, 0, 0, 1, 2'd1, 8'h00, 0);
    // R7: masks written per byte and read back
    cyc("R7", 1, 0, 2'd3, 8'h02, 64'hFF00, 1, 0, 2'd3, 8'h01, 64'h00FF);
    cyc("R7", 0, 1, 2'd3, 8'h00, 0, 0, 1, 2'd3, 8'h00, 0);
    // R2: host fills four inbound bytes; back-end irq rises (R7)
    cyc("R2", 1, 0, 2'd0, 8'h0F, 64'h1122334455667788, 0, 0, 0, 0, 0);
    cyc("R2", 0, 1, 2'd2, 8'h00, 0, 0, 1, 2'd2, 8'h00, 0);
    // R3: back-end drains bytes 0,1; host sees taken events (R5)
    cyc("R3", 0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h03, 0);
    cyc("R5", 0, 1, 2'd2, 0, 0, 0, 1, 2'd2, 0, 0);
    // R10: draining empty bytes 4,5 and leaving byte 2 undisturbed
    cyc("R10", 0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h30, 0);
    cyc("R10", 0, 1, 2'd2, 0, 0, 0, 1, 2'd2, 0, 0);
    // R6: clear bit 8 only; then disabled byte leaves bit 9
    cyc("R6", 1, 0, 2'd2, 8'h03, 64'h0100, 0, 0, 0, 0, 0);
    cyc("R6", 1, 1, 2'd2, 8'h01, 64'h0200, 0, 0, 0, 0, 0);
    cyc("R6", 0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0);
    // R6: clear and new arrival in the same cycle
    cyc("R6", 0, 0, 0, 0, 0, 1, 0, 2'd2, 8'h01, 64'h0001);
    cyc("R6", 1, 0, 2'd0, 8'h01, 64'hAA, 1, 0, 2'd2, 8'h01, 64'h0001);
    cyc("R6", 0, 0, 0, 0, 0, 0, 1, 2'd2, 0, 0);
    // R4: back-end fills outbound word, host drains upper half
    cyc("R4", 0, 0, 0, 0, 0, 1, 0, 2'd1, 8'hFF, 64'hCAFEF00D_DEADBEEF);
    cyc("R4", 0, 1, 2'd1, 8'hF0, 0, 0, 1, 2'd2, 0, 0);
    cyc("R4", 0, 1, 2'd2, 0, 0, 0, 1, 2'd2, 0, 0);
    // R8: writes to the wrong mailbox and to read-only status bits
    cyc("R8", 1, 0, 2'd1, 8'hFF, 64'h0, 1, 0, 2'd0, 8'hFF, 64'h0);
    cyc("R8", 1, 0, 2'd2, 8'hFC, 64'hFFFF_FFFF_FFFF_0000, 0, 0, 0, 0, 0);
    cyc("R8", 0, 1, 2'd1, 8'h00, 0, 0, 1, 2'd0, 8'h00, 0);
    cyc("R8", 0, 1, 2'd2, 0, 0, 0, 1, 2'd2, 0, 0);
    // R9: write and drain byte 2 in the same cycle
    cyc("R9", 1, 0, 2'd0, 8'h04, 64'h0000_0000_0077_0000, 0, 1, 2'd0, 8'h04, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 1, 2'd2, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h00, 0);
    // R11: overwrite full byte 3
    cyc("R11", 1, 0, 2'd0, 8'h08, 64'h0000_0000_5500_0000, 1, 0, 2'd2, 8'h01, 64'hFF);
    cyc("R11", 0, 0, 0, 0, 0, 0, 1, 2'd0, 8'h00, 0);
    cyc("R11", 0, 0, 0, 0, 0, 0, 1, 2'd2, 0, 0);
    // R12: no read strobe gives zero data
    cyc("R12", 0, 0, 2'd0, 8'hFF, 0, 0, 0, 2'd2, 8'hFF, 0);
    idle("R12");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule